// File: doc/BRIEF.md
# Split-Write Port Register Combiner

This block is the 32-bit memory-mapped front end of a network controller. A bus master performs word accesses at four word-aligned offsets. A write to the first offset requests a controller reset, and a write to the third raises channel attention. A write to the fourth forwards a station-address request that carries the written address. The second offset is the port register: a port command reaches it as two consecutive writes, the low half first and the high half second.

The block holds the first port write. When the second write arrives, it joins the two halves into one command. The opcode is the low byte of the first write. The argument is the joined 32-bit value with that byte cleared. The block emits the command as a one-cycle valid together with the opcode, a decoded opcode class and the argument. Reads return a fixed identification word at the station offset and all ones everywhere else.

All outputs are registered. Every action appears exactly one clock after the access that causes it and lasts for one cycle.

Top module: `portreg_front`

## Requirements
- R1: While reset is high and in the first cycle after it, soft_rst, attn, sid_req, port_valid and rd_valid are low. After reset the port register expects a first (low-half) write.
- R2: A valid write to offset 0 pulses soft_rst high for exactly the cycle after the write, whatever the data.
- R3: A valid write to offset 8 pulses attn high for exactly the cycle after the write, whatever the data.
- R4: The first valid write to offset 4 produces no port_valid. The next valid write to offset 4 pulses port_valid in the following cycle. In that pulse, port_op equals bits 7:0 of the first write, and port_arg equals (first | second << 16) with bits 7:0 forced to zero, truncated to 32 bits.
- R5: After a completed pair, the next write to offset 4 is again treated as a first write, so port commands fire on every second port write.
- R6: A hardware reset, or a valid write to offset 0, between the two halves discards the held half. The next port write then starts a new pair.
- R7: A valid write to offset 12 pulses sid_req in the following cycle, with sid_addr equal to the written data.
- R8: A read pulses rd_valid in the following cycle. rdata is 32'hBEEFBABE for a valid read of offset 12 and 32'hFFFFFFFF for every other read.
- R9: An access is valid only if byte_en is 4'b1111 and addr is one of 0, 4, 8 or 12. Any other write changes no output and leaves the pairing state unchanged.
- R10: port_kind classifies port_op as follows: 0 for reset, 1 for self-test, 2 for alternate control-block address, 3 for alternate dump address, and 7 for any other opcode value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (5) | Byte offset of the access |
| byte_en | input | 4 | Byte enables; only 4'b1111 is a valid access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response, one cycle after rd_en |
| soft_rst | output | 1 | Controller reset pulse |
| attn | output | 1 | Channel-attention pulse |
| sid_req | output | 1 | Station-address request pulse |
| sid_addr | output | 32 | Destination address for the station ID |
| port_valid | output | 1 | Joined port command pulse |
| port_op | output | 8 | Port opcode (low byte of first half) |
| port_kind | output | 3 | Decoded opcode class |
| port_arg | output | 32 | Joined argument with low byte cleared |

## Verification
Every result of this block, whether a strobe, a joined port command or a read response, is due in the single cycle after the access that causes it, and it is gone one cycle later. The bench drives each access on a falling edge and lets one rising edge pass. It then samples every output at the next falling edge, where the response to that access and nothing else is visible. A bench model of the pairing phase and the held half predicts the outputs of each access. Idle-free back-to-back accesses also show that no pulse lasts longer than its cycle.

// File: rtl/portreg_pkg.sv
package portreg_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int OP_W   = 8;
    localparam int BE_W   = DATA_W / 8;

    localparam int OFS_RESET = 0;
    localparam int OFS_PORT  = 4;
    localparam int OFS_ATTN  = 8;
    localparam int OFS_SID   = 12;

    localparam logic [DATA_W-1:0] SID_READ_WORD = 32'hBEEF_BABE;
    localparam logic [DATA_W-1:0] IDLE_READ_WORD = '1;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_RESET = 3'd1,
        SEL_PORT  = 3'd2,
        SEL_ATTN  = 3'd3,
        SEL_SID   = 3'd4
    } sel_e;

    typedef enum logic [2:0] {
        PK_RESET    = 3'd0,
        PK_SELFTEST = 3'd1,
        PK_ALTCB    = 3'd2,
        PK_ALTDUMP  = 3'd3,
        PK_OTHER    = 3'd7
    } port_kind_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        port_kind_e        kind;
        logic [DATA_W-1:0] arg;
    } port_cmd_t;

    function automatic port_kind_e classify_op(input logic [OP_W-1:0] op);
        port_kind_e k;
        case (op)
            8'd0:    k = PK_RESET;
            8'd1:    k = PK_SELFTEST;
            8'd2:    k = PK_ALTCB;
            8'd3:    k = PK_ALTDUMP;
            default: k = PK_OTHER;
        endcase
        return k;
    endfunction

    function automatic logic [DATA_W-1:0] join_halves(input logic [DATA_W-1:0] first,
                                                      input logic [DATA_W-1:0] second);
        logic [DATA_W-1:0] v;
        v = first | (second << HALF_W);
        v[OP_W-1:0] = '0;
        return v;
    endfunction

endpackage

// File: rtl/portreg_decode.sv
module portreg_decode
    import portreg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   byte_en,
    output sel_e              wr_sel,
    output sel_e              rd_sel
);
    sel_e  hit;
    logic  full_word;

    always_comb begin
        full_word = (byte_en == {BE_W{1'b1}});
        case (addr)
            ADDR_W'(OFS_RESET): hit = SEL_RESET;
            ADDR_W'(OFS_PORT):  hit = SEL_PORT;
            ADDR_W'(OFS_ATTN):  hit = SEL_ATTN;
            ADDR_W'(OFS_SID):   hit = SEL_SID;
            default:            hit = SEL_NONE;
        endcase
        wr_sel = (wr_en && full_word) ? hit : SEL_NONE;
        rd_sel = (rd_en && full_word) ? hit : SEL_NONE;
    end
endmodule

// File: rtl/portreg_pair.sv
module portreg_pair
    import portreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_port,
    input  logic              clear,
    input  logic [DATA_W-1:0] wdata,
    output logic              cmd_valid,
    output port_cmd_t         cmd
);
    typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} phase_e;

    phase_e            phase;
    logic [DATA_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_FIRST;
            held      <= '0;
            cmd_valid <= 1'b0;
            cmd       <= '{op: '0, kind: PK_RESET, arg: '0};
        end else begin
            cmd_valid <= 1'b0;
            if (clear) begin
                phase <= PH_FIRST;
            end else if (wr_port) begin
                if (phase == PH_FIRST) begin
                    held  <= wdata;
                    phase <= PH_SECOND;
                end else begin
                    phase     <= PH_FIRST;
                    cmd_valid <= 1'b1;
                    cmd.op    <= held[OP_W-1:0];
                    cmd.kind  <= classify_op(held[OP_W-1:0]);
                    cmd.arg   <= join_halves(held, wdata);
                end
            end
        end
    end
endmodule

// File: rtl/portreg_strobes.sv
module portreg_strobes
    import portreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sel_e              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              soft_rst,
    output logic              attn,
    output logic              sid_req,
    output logic [DATA_W-1:0] sid_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            soft_rst <= 1'b0;
            attn     <= 1'b0;
            sid_req  <= 1'b0;
            sid_addr <= '0;
        end else begin
            soft_rst <= (wr_sel == SEL_RESET);
            attn     <= (wr_sel == SEL_ATTN);
            sid_req  <= (wr_sel == SEL_SID);
            if (wr_sel == SEL_SID) sid_addr <= wdata;
        end
    end
endmodule

// File: rtl/portreg_readback.sv
module portreg_readback
    import portreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  sel_e              rd_sel,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rdata    <= IDLE_READ_WORD;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= (rd_sel == SEL_SID) ? SID_READ_WORD : IDLE_READ_WORD;
        end
    end
endmodule

// File: rtl/portreg_front.sv
module portreg_front
    import portreg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        byte_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rd_valid,
    output logic              soft_rst,
    output logic              attn,
    output logic              sid_req,
    output logic [31:0]       sid_addr,
    output logic              port_valid,
    output logic [7:0]        port_op,
    output logic [2:0]        port_kind,
    output logic [31:0]       port_arg
);
    sel_e      wr_sel;
    sel_e      rd_sel;
    port_cmd_t cmd;

    portreg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .byte_en (byte_en),
        .wr_sel  (wr_sel),
        .rd_sel  (rd_sel)
    );

    portreg_pair u_pair (
        .clk       (clk),
        .rst       (rst),
        .wr_port   (wr_sel == SEL_PORT),
        .clear     (wr_sel == SEL_RESET),
        .wdata     (wdata),
        .cmd_valid (port_valid),
        .cmd       (cmd)
    );

    portreg_strobes u_stb (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (wr_sel),
        .wdata    (wdata),
        .soft_rst (soft_rst),
        .attn     (attn),
        .sid_req  (sid_req),
        .sid_addr (sid_addr)
    );

    portreg_readback u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .rd_valid (rd_valid),
        .rdata    (rdata)
    );

    assign port_op   = cmd.op;
    assign port_kind = cmd.kind;
    assign port_arg  = cmd.arg;
endmodule

// File: rtl/portreg_front_chk.sv
module portreg_front_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        byte_en,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              rd_valid,
    input logic              soft_rst,
    input logic              attn,
    input logic              sid_req,
    input logic [31:0]       sid_addr,
    input logic              port_valid,
    input logic [31:0]       port_arg
);
    logic good;
    assign good = (byte_en == 4'hF);

    // R2
    p_rst_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && good && addr == ADDR_W'(0)) |=> soft_rst);
    // R3
    p_attn_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && good && addr == ADDR_W'(8)) |=> attn);
    // R4
    p_port_from_write_r4: assert property (@(posedge clk) disable iff (rst)
        port_valid |-> ($past(wr_en) && $past(byte_en) == 4'hF && $past(addr) == ADDR_W'(4)));
    p_port_lowbyte_r4: assert property (@(posedge clk) disable iff (rst)
        port_valid |-> (port_arg[7:0] == 8'h00));
    // R7
    p_sid_addr_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && good && addr == ADDR_W'(12)) |=> (sid_req && sid_addr == $past(wdata)));
    // R8
    p_rd_resp_r8: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    p_rd_sid_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && good && addr == ADDR_W'(12)) |=> (rdata == 32'hBEEF_BABE));
    // R9
    p_bad_width_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!good) |=> !(soft_rst || attn || sid_req || port_valid));
    p_one_action_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({soft_rst, attn, sid_req, port_valid}));
endmodule

bind portreg_front portreg_front_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .byte_en    (byte_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .rd_valid   (rd_valid),
    .soft_rst   (soft_rst),
    .attn       (attn),
    .sid_req    (sid_req),
    .sid_addr   (sid_addr),
    .port_valid (port_valid),
    .port_arg   (port_arg)
);

// File: tb/sim_portreg_front.sv
`timescale 1ns/1ps
module sim_portreg_front;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    byte_en = 4'hF;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata, sid_addr, port_arg;
    logic          rd_valid, soft_rst, attn, sid_req, port_valid;
    logic [7:0]    port_op;
    logic [2:0]    port_kind;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit          m_second = 1'b0;
    logic [31:0] m_held   = '0;

    always #4 clk = ~clk;

    portreg_front #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .soft_rst(soft_rst), .attn(attn), .sid_req(sid_req), .sid_addr(sid_addr),
        .port_valid(port_valid), .port_op(port_op), .port_kind(port_kind),
        .port_arg(port_arg)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [2:0] exp_kind(input logic [7:0] op);
        return (op < 8'd4) ? op[2:0] : 3'd7;
    endfunction

    function automatic logic [31:0] exp_arg(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] v;
        v = a | (b << 16);
        return v & 32'hFFFF_FF00;
    endfunction

    function automatic bit mapped(input logic [AW-1:0] a);
        return (a == 5'd0) || (a == 5'd4) || (a == 5'd8) || (a == 5'd12);
    endfunction

    task automatic access(input bit w, input bit r, input logic [AW-1:0] a,
                          input logic [3:0] be, input logic [31:0] d);
        bit ok, e_rst, e_attn, e_sid, e_port;
        logic [31:0] e_arg;
        logic [7:0]  e_op;
        wr_en = w; rd_en = r; addr = a; byte_en = be; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        ok     = (be == 4'hF) && mapped(a);
        e_rst  = w && ok && a == 5'd0;
        e_attn = w && ok && a == 5'd8;
        e_sid  = w && ok && a == 5'd12;
        e_port = w && ok && a == 5'd4 && m_second;
        e_op   = m_held[7:0];
        e_arg  = exp_arg(m_held, d);
        check("R2 soft_rst", 32'(soft_rst), 32'(e_rst));
        check("R3 attn", 32'(attn), 32'(e_attn));
        check("R7 sid_req", 32'(sid_req), 32'(e_sid));
        check("R4/R5/R6/R9 port_valid", 32'(port_valid), 32'(e_port));
        if (e_sid) check("R7 sid_addr", sid_addr, d);
        if (e_port) begin
            check("R4 port_op", 32'(port_op), 32'(e_op));
            check("R4 port_arg", port_arg, e_arg);
            check("R10 port_kind", 32'(port_kind), 32'(exp_kind(e_op)));
        end
        check("R8 rd_valid", 32'(rd_valid), 32'(r));
        if (r) check("R8 rdata", rdata, (ok && a == 5'd12) ? 32'hBEEF_BABE : 32'hFFFF_FFFF);
        if (e_rst) m_second = 1'b0;
        else if (w && ok && a == 5'd4) begin
            if (!m_second) m_held = d;
            m_second = ~m_second;
        end
    endtask

    task automatic hw_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 soft_rst in reset", 32'(soft_rst), 0);
        check("R1 port_valid in reset", 32'(port_valid), 0);
        check("R1 rd_valid in reset", 32'(rd_valid), 0);
        rst = 1'b0;
        m_second = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 strobes after reset", 32'({soft_rst, attn, sid_req, port_valid, rd_valid}), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        hw_reset();
        // R4 basic pair, R10 kinds
        access(1, 0, 5'd4, 4'hF, 32'h1234_5602);
        access(1, 0, 5'd4, 4'hF, 32'h0000_ABCD);
        access(1, 0, 5'd4, 4'hF, 32'hDEAD_BE03);
        access(1, 0, 5'd4, 4'hF, 32'hFFFF_FFFF);
        access(1, 0, 5'd4, 4'hF, 32'h0000_0099);
        access(1, 0, 5'd4, 4'hF, 32'h0000_0001);
        // R6 reset write between halves
        access(1, 0, 5'd4, 4'hF, 32'h0000_0001);
        access(1, 0, 5'd0, 4'hF, 32'h0);
        access(1, 0, 5'd4, 4'hF, 32'h0000_7701);
        access(1, 0, 5'd4, 4'hF, 32'h0000_1111);
        // R6 hardware reset between halves
        access(1, 0, 5'd4, 4'hF, 32'h0000_0002);
        hw_reset();
        access(1, 0, 5'd4, 4'hF, 32'h5555_0000);
        access(1, 0, 5'd4, 4'hF, 32'h0000_0004);
        // R9 partial byte enables and misaligned/unmapped writes mid-pair
        access(1, 0, 5'd4, 4'hF, 32'hAAAA_0003);
        access(1, 0, 5'd4, 4'h3, 32'h1);
        access(1, 0, 5'd6, 4'hF, 32'h2);
        access(1, 0, 5'd16, 4'hF, 32'h3);
        access(1, 0, 5'd0, 4'hC, 32'h4);
        access(1, 0, 5'd8, 4'h0, 32'h5);
        access(1, 0, 5'd4, 4'hF, 32'h0000_BEEF);
        // R3 back to back, R7, R8 reads
        access(1, 0, 5'd8, 4'hF, 32'h0);
        access(1, 0, 5'd8, 4'hF, 32'hFFFF_FFFF);
        access(1, 0, 5'd12, 4'hF, 32'h0040_1000);
        access(0, 1, 5'd12, 4'hF, 32'h0);
        access(0, 1, 5'd12, 4'h1, 32'h0);
        access(0, 1, 5'd4, 4'hF, 32'h0);
        access(0, 1, 5'd20, 4'hF, 32'h0);
        // constrained random
        void'($urandom(32'd2024));
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            logic [3:0]    be;
            int            sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: a = 5'd0;
                1, 2, 3, 4: a = 5'd4;
                5: a = 5'd8;
                6: a = 5'd12;
                default: a = AW'($urandom);
            endcase
            be = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
            if ($urandom_range(0, 3) == 0) access(0, 1, a, be, $urandom);
            else if ($urandom_range(0, 15) == 0) access(1, 1, a, be, $urandom);
            else access(1, 0, a, be, $urandom);
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule